// File: doc/BRIEF.md
# Reload Serial Clock Generator

This block divides the bus clock down to a serial shift clock. A 15-bit down-counter is loaded with a programmable reload value and counts down to zero. Each wrap starts a new serial clock period of reload-plus-one bus clocks. Every period begins with its high phase. A one-cycle tick marks the first bus clock of each period, so shift logic further down can move one bit per tick.

When the reload value is odd, the period has an even length and the two phases are equal. When it is even, one phase gets the extra bus clock, and the inversion input picks which one. A value written while the divider runs waits in a holding register until the running period ends, so no period is ever cut short. A soft reset bypasses that wait and restarts the counter at once with the newest value. Until the first write the divider stays idle, with the serial clock parked high.

Top module: `sclk_reload_gen`

## Requirements
- R1: After reset the serial clock is 1 and the tick is 0. Both stay that way until the first reload write. The first write starts the counter, and the first tick follows reload+1 bus clocks later.
- R2: While enabled and running, the tick is high for exactly one bus clock. Successive ticks are reload+1 bus clocks apart.
- R3: With an odd reload value R, the high phase and the low phase are each (R+1)/2 bus clocks.
- R4: With an even reload value R and inversion input 0, the high phase is R/2+1 bus clocks and the low phase is R/2.
- R5: With an even reload value R and inversion input 1, the high phase is R/2 bus clocks and the low phase is R/2+1.
- R6: A reload value below 3 (0, 1 or 2) behaves exactly as 3, giving a 4-clock period.
- R7: A reload write without soft reset, made while the counter runs, does not change the period in progress. The new value governs every period after the next wrap.
- R8: A soft reset restarts the counter on the next bus clock edge. It loads the value written in the same cycle, or the last written value if there is none. The serial clock is 1 in the cycle after the soft reset, and the next tick comes reload+1 clocks later.
- R9: While the enable input is 0, the counter holds its value, the serial clock keeps its level and no tick is produced. Counting resumes where it stopped.
- R10: Each tick coincides with the serial clock being 1, the first cycle of the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Count enable; 0 freezes the divider |
| reload_val | input | 15 | Reload value (period minus one) |
| reload_wr | input | 1 | Write strobe for reload_val |
| sclk_inv | input | 1 | Chooses which phase takes the extra clock for even reload values |
| soft_rst | input | 1 | Loads the newest reload value into the counter at once |
| sclk | output | 1 | Serial clock |
| baud_tick | output | 1 | One-cycle pulse at the start of each serial clock period |

## Verification
The phase measurement is run on an odd reload value and on an even one under both inversion settings. This separates the equal split from the two uneven splits and catches a swapped inversion. Seeded random reload values from 0 to 40, each with a random inversion setting, add coverage across both parities and the clamped range. A write made in the middle of a period shows whether the change is deferred or applied at once. A soft reset made mid-period shows whether the bypass restarts immediately. A stretch with the enable low shows whether the count freezes or keeps running behind the scenes.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int SRG_CNT_W      = 15;
  localparam int SRG_MIN_RELOAD = 3;

  typedef enum logic [1:0] {
    SRG_LD_NONE,
    SRG_LD_START,
    SRG_LD_SOFT,
    SRG_LD_WRAP
  } srg_load_e;
endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/srg_divisor.sv
module srg_divisor #(
  parameter int CNT_W      = srg_pkg::SRG_CNT_W,
  parameter int MIN_RELOAD = srg_pkg::SRG_MIN_RELOAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] load_val_o,
  output logic [CNT_W-1:0] act_nxt_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_RELOAD);

  logic [CNT_W-1:0] pend_q, pend_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] wr_clamped;

  always_comb begin
    wr_clamped = (val_i < MIN_V) ? MIN_V : val_i;
    pend_d     = wr_i ? wr_clamped : pend_q;
    act_d      = load_i ? pend_d : act_q;
  end

  assign load_val_o = pend_d;
  assign act_nxt_o  = act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= MIN_V;
      act_q  <= MIN_V;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  // R6: the divisor in use never drops below the minimum
  a_r6_active_min: assert property (@(posedge clk) disable iff (!rst_n)
    act_q >= MIN_V);
  // R6: a stored write is always at least the minimum
  a_r6_pend_min: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_q >= MIN_V);
endmodule

// File: rtl/srg_counter.sv
module srg_counter #(
  parameter int CNT_W = srg_pkg::SRG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             soft_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             run_o,
  output logic             run_nxt_o,
  output logic             load_o,
  output logic             tick_o
);
  import srg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  srg_load_e        kind;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             tick_q, tick_d;

  always_comb begin
    if (soft_i)                          kind = SRG_LD_SOFT;
    else if (wr_i && !run_q)             kind = SRG_LD_START;
    else if (run_q && en_i && cnt_q == '0) kind = SRG_LD_WRAP;
    else                                 kind = SRG_LD_NONE;

    case (kind)
      SRG_LD_NONE: cnt_d = (run_q && en_i) ? cnt_q - CNT_ONE : cnt_q;
      default:     cnt_d = load_val_i;
    endcase

    run_d  = run_q | wr_i;
    tick_d = (kind == SRG_LD_WRAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      tick_q <= tick_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign run_o     = run_q;
  assign run_nxt_o = run_d;
  assign load_o    = (kind != SRG_LD_NONE);
  assign tick_o    = tick_q;

  // R2: tick lasts a single bus clock
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  // R2: a tick only follows a counter that sat at zero
  a_r2_tick_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(cnt_q) == '0);
  // R7: a plain write never disturbs the countdown of a running period
  a_r7_write_defers: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && en_i && !soft_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_ONE);
  // R9: disabled counter holds and stays silent
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !en_i && !soft_i |=> $stable(cnt_q) && !tick_q);
endmodule

// File: rtl/srg_phase.sv
module srg_phase #(
  parameter int CNT_W = srg_pkg::SRG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_i,
  input  logic             run_nxt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] act_nxt_i,
  output logic             sclk_o
);
  localparam int W1 = CNT_W + 1;

  logic [W1-1:0] act_ext, low_w;
  logic          sclk_q, sclk_d;

  always_comb begin
    act_ext = {1'b0, act_nxt_i};
    // low phase = floor((R+1)/2) normally, ceil((R+1)/2) when inverted
    low_w   = (act_ext + (inv_i ? W1'(2) : W1'(1))) >> 1;
    sclk_d  = run_nxt_i ? ({1'b0, cnt_nxt_i} >= low_w) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_d;
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/sclk_reload_gen.sv
module sclk_reload_gen #(
  parameter int CNT_W      = srg_pkg::SRG_CNT_W,
  parameter int MIN_RELOAD = srg_pkg::SRG_MIN_RELOAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_wr,
  input  logic             sclk_inv,
  input  logic             soft_rst,
  output logic             sclk,
  output logic             baud_tick
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] load_val, act_nxt, cnt_nxt;
  logic             load, run, run_nxt;

  srg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srg_divisor #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (reload_wr),
    .val_i      (reload_val),
    .load_i     (load),
    .load_val_o (load_val),
    .act_nxt_o  (act_nxt)
  );

  srg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (en),
    .soft_i     (soft_rst),
    .wr_i       (reload_wr),
    .load_val_i (load_val),
    .cnt_nxt_o  (cnt_nxt),
    .run_o      (run),
    .run_nxt_o  (run_nxt),
    .load_o     (load),
    .tick_o     (baud_tick)
  );

  srg_phase #(.CNT_W(CNT_W)) u_ph (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inv_i     (sclk_inv),
    .run_nxt_i (run_nxt),
    .cnt_nxt_i (cnt_nxt),
    .act_nxt_i (act_nxt),
    .sclk_o    (sclk)
  );

  // R1: idle divider keeps the clock parked high and silent
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |-> sclk && !baud_tick);
  // R10: every period opens with the high phase
  a_r10_tick_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    baud_tick |-> sclk);
  // R8: soft reset starts a fresh high phase on the next edge
  a_r8_soft_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst && (run || reload_wr) |=> sclk && !baud_tick);
endmodule

// File: tb/sim_sclk_reload_gen.sv
module sim_sclk_reload_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [14:0] reload_val;
  logic        reload_wr;
  logic        sclk_inv;
  logic        soft_rst;
  logic        sclk;
  logic        baud_tick;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5ns clk = ~clk;

  sclk_reload_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .reload_val(reload_val),
    .reload_wr(reload_wr), .sclk_inv(sclk_inv), .soft_rst(soft_rst),
    .sclk(sclk), .baud_tick(baud_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int r);
    return (r < 3) ? 3 : r;
  endfunction
  function automatic int exp_hi(input int r, input bit inv);
    int e = eff(r);
    if (e % 2 == 1) return (e + 1) / 2;
    return inv ? e / 2 : e / 2 + 1;
  endfunction
  function automatic int exp_lo(input int r, input bit inv);
    return eff(r) + 1 - exp_hi(r, inv);
  endfunction

  task automatic wait_tick(output bit ok);
    int k = 0;
    while (!baud_tick && k < 3000) begin
      @(negedge clk);
      k++;
    end
    ok = baud_tick;
  endtask

  // called at a negedge where baud_tick is high
  task automatic measure(output int hi, output int lo, output int s0);
    s0 = sclk;
    hi = 0;
    lo = 0;
    do begin
      if (sclk) hi++; else lo++;
      @(negedge clk);
    end while (!baud_tick && hi + lo < 70000);
  endtask

  task automatic soft_load(input int v, input bit inv);
    reload_val = 15'(v);
    reload_wr  = 1'b1;
    soft_rst   = 1'b1;
    sclk_inv   = inv;
    @(negedge clk);
    reload_wr  = 1'b0;
    soft_rst   = 1'b0;
  endtask

  task automatic check_shape(input int r, input bit inv, input string tag);
    bit ok;
    int hi, lo, s0;
    wait_tick(ok);
    chk(ok, {tag, " tick seen"}, ok, 1);
    measure(hi, lo, s0);
    chk(hi + lo == eff(r) + 1, {tag, " R2 period"}, hi + lo, eff(r) + 1);
    chk(hi == exp_hi(r, inv), {tag, " high width"}, hi, exp_hi(r, inv));
    chk(lo == exp_lo(r, inv), {tag, " low width"}, lo, exp_lo(r, inv));
    chk(s0 == 1, {tag, " R10 sclk at tick"}, s0, 1);
  endtask

  initial begin
    #750us;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int bad, n;
    bit ok;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; en = 1'b1; reload_val = '0; reload_wr = 1'b0;
    sclk_inv = 1'b0; soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
    chk(baud_tick == 1'b0, "R1 reset tick", baud_tick, 0);
    rst_n = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!sclk || baud_tick) bad++;
    end
    chk(bad == 0, "R1 idle before write", bad, 0);

    // R1: plain write from idle starts the counter
    reload_val = 15'd4; reload_wr = 1'b1;
    @(negedge clk);
    reload_wr = 1'b0;
    n = 0;
    while (!baud_tick && n < 100) begin n++; @(negedge clk); end
    chk(n == 5, "R1 first tick delay", n, 5);

    soft_load(3, 1'b0); check_shape(3, 1'b0, "R3 odd");
    soft_load(7, 1'b1); check_shape(7, 1'b1, "R3 odd inv");
    soft_load(6, 1'b0); check_shape(6, 1'b0, "R4 even");
    soft_load(6, 1'b1); check_shape(6, 1'b1, "R5 even inv");
    soft_load(0, 1'b0); check_shape(0, 1'b0, "R6 clamp0");
    soft_load(2, 1'b1); check_shape(2, 1'b1, "R6 clamp2");

    // R7: write mid-period is deferred
    soft_load(5, 1'b0);
    wait_tick(ok);
    n = 0;
    do begin
      if (n == 2) begin reload_val = 15'd9; reload_wr = 1'b1; end
      else reload_wr = 1'b0;
      n++;
      @(negedge clk);
    end while (!baud_tick && n < 100);
    reload_wr = 1'b0;
    chk(n == 6, "R7 current period kept", n, 6);
    begin
      int hi, lo, s0;
      measure(hi, lo, s0);
      chk(hi + lo == 10, "R7 new period after wrap", hi + lo, 10);
    end

    // R8: soft reset mid-period restarts at once
    wait_tick(ok);
    repeat (3) @(negedge clk);
    reload_val = 15'd4; reload_wr = 1'b1; soft_rst = 1'b1;
    @(negedge clk);
    reload_wr = 1'b0; soft_rst = 1'b0;
    chk(sclk == 1'b1, "R8 sclk high after soft reset", sclk, 1);
    n = 0;
    while (!baud_tick && n < 100) begin n++; @(negedge clk); end
    chk(n == 5, "R8 restart length", n, 5);

    // R9: enable low freezes
    soft_load(7, 1'b0);
    wait_tick(ok);
    en = 1'b0;
    bad = 0;
    n = 0;
    repeat (10) begin
      @(negedge clk);
      n++;
      if (baud_tick || !sclk) bad++;
    end
    chk(bad == 0, "R9 frozen outputs", bad, 0);
    en = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 200);
    chk(n == 18, "R9 resumed period", n, 18);

    // random reload values and inversion settings
    for (int i = 0; i < 24; i++) begin
      int r;
      bit inv;
      r   = int'($urandom % 41);
      inv = 1'($urandom % 2);
      soft_load(r, inv);
      check_shape(r, inv, "R2 R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule